// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is one general-purpose I/O port of eight pins. Each pin has its own direction bit and output data bit, written and read through a small register interface. Each pin can also be handed to an on-chip peripheral. A pin handed over in this way takes both its driven value and its output enable from that peripheral. Its direction bit then has no effect on the pad, whatever value it holds.

The pad side is modelled as three separate vectors: output value, output enable, and sampled input. The pad cell outside the block combines them. Reads of the data address return the pin levels after a two-flop synchronizer, not the output latch. Reads of the direction address return the stored bits, whether or not a peripheral is overriding the pin.

Three registers sit behind a two-bit address: output latch (0), direction (1), peripheral select (2). Address 3 is unused.

Top module: `gpio_override_port`

## Requirements
- R1: After reset all direction bits read 1, the peripheral select register reads 0, the output latch is 0, padOe is all 0 and padOut is all 0.
- R2: A write with busAddr=0 loads the output latch. A read at busAddr=0 returns the synchronized pad inputs and never the latch.
- R3: For a pin whose select bit is 0, padOe equals the inverse of its direction bit (direction 1 = input, 0 = output) and padOut equals its latch bit.
- R4: For a pin whose select bit is 1, padOut equals periOut and padOe equals periOe for that pin, whatever its direction bit.
- R5: periOut and periOe have no effect on a pin whose select bit is 0.
- R6: A write with busAddr=1 stores the direction bits, even for pins under override. A read at busAddr=1 returns the stored bits, not the effective direction.
- R7: A change on padIn appears in the busAddr=0 read data after exactly two rising clock edges, and not after one.
- R8: A write with busAddr=2 stores the peripheral select bits (bit i hands pin i to its peripheral). A read at busAddr=2 returns them.
- R9: A write with busAddr=3 changes no register. A read at busAddr=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 latch/pins, 1 direction, 2 select, 3 unused |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| periOut | input | 8 | Peripheral output values, one per pin |
| periOe | input | 8 | Peripheral output enables, one per pin |
| padIn | input | 8 | Levels sampled from the pads |
| padOut | output | 8 | Value to drive on each pad |
| padOe | output | 8 | Pad driver enable (1 = drive) |

## Verification
A corrupted direction or select bit shows on padOe or padOut in the cycle right after the faulty write, because both outputs are combinational from the registers. A wrong stored value is also visible straight away in the register readback. A synchronizer that is too short or too long moves the pin readback by one edge, so a check taken after each edge exposes it. The sweep over every select pattern, with varied direction, latch and peripheral values, reaches a fault in any single pin's mux within the first few hundred cycles.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_PINS = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_SEL  = 2'd2,
    ADDR_NONE = 2'd3
  } regAddrE;

  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    logic    wrSel;
    regAddrE rdPick;
  } portStrobeT;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic       busWr,
  input  logic [1:0] busAddr,
  output portStrobeT strobes
);
  regAddrE addrKind;

  always_comb begin
    addrKind        = regAddrE'(busAddr);
    strobes.wrLatch = busWr && (addrKind == ADDR_PINS);
    strobes.wrDir   = busWr && (addrKind == ADDR_DIR);
    strobes.wrSel   = busWr && (addrKind == ADDR_SEL);
    strobes.rdPick  = addrKind;
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  portStrobeT       strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] periOut,
  input  logic [WIDTH-1:0] periOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] selQ,
  output logic [WIDTH-1:0] syncQ
);
  localparam logic [WIDTH-1:0] ALL_INPUT = '1;

  logic [WIDTH-1:0] syncChain [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ <= '0;
      dirQ   <= ALL_INPUT;
      selQ   <= '0;
    end else begin
      if (strobes.wrLatch) latchQ <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
      if (strobes.wrSel)   selQ   <= wrData;
    end
  end

  generate
    for (genvar st = 0; st < SYNC_STAGES; st++) begin : gSync
      always_ff @(posedge clk) begin
        if (rst) syncChain[st] <= '0;
        else if (st == 0) syncChain[st] <= padIn;
        else syncChain[st] <= syncChain[(st == 0) ? 0 : st-1];
      end
    end
  endgenerate

  assign syncQ = syncChain[SYNC_STAGES-1];

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : gPin
      assign padOut[p] = selQ[p] ? periOut[p] : latchQ[p];
      assign padOe[p]  = selQ[p] ? periOe[p]  : ~dirQ[p];
    end
  endgenerate

  always_comb begin
    case (strobes.rdPick)
      ADDR_PINS: rdData = syncQ;
      ADDR_DIR:  rdData = dirQ;
      ADDR_SEL:  rdData = selQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] periOut,
  input  logic [WIDTH-1:0] periOe,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);
  portStrobeT       strobes;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] selQ;
  logic [WIDTH-1:0] syncQ;

  gpio_port_ctrl uCtrl (
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_port_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (busWrData),
    .periOut (periOut),
    .periOe  (periOe),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (busRdData),
    .latchQ  (latchQ),
    .dirQ    (dirQ),
    .selQ    (selQ),
    .syncQ   (syncQ)
  );
endmodule

// File: rtl/gpio_override_port_checker.sv
module gpio_override_port_checker #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [WIDTH-1:0] busWrData,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] latchQ,
  input logic [WIDTH-1:0] dirQ,
  input logic [WIDTH-1:0] selQ,
  input logic [WIDTH-1:0] syncQ
);
  logic       rstSeen;
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  always @(posedge clk) begin
    if (rstSeen === 1'b1) begin
      assert_reset_state_R1: assert (dirQ == '1 && latchQ == '0 && selQ == '0)
        else $error("reset state wrong");
    end
  end

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == 2'd0) |=> latchQ == $past(busWrData));

  assert_dir_write_R6: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == 2'd1) |=> dirQ == $past(busWrData));

  assert_sel_write_R8: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == 2'd2) |=> selQ == $past(busWrData));

  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == 2'd3) |=> ($stable(dirQ) && $stable(latchQ) && $stable(selQ)));

  generate
    if (SYNC_STAGES == 2) begin : gSyncChk
      assert_sync_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 2'd2) |-> syncQ == $past(padIn, 2));
    end
  endgenerate
endmodule

bind gpio_override_port gpio_override_port_checker #(
  .WIDTH       (WIDTH),
  .SYNC_STAGES (SYNC_STAGES)
) uChecker (
  .clk       (clk),
  .rst       (rst),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .padIn     (padIn),
  .latchQ    (latchQ),
  .dirQ      (dirQ),
  .selQ      (selQ),
  .syncQ     (syncQ)
);

// File: tb/gpio_override_port_test.sv
`timescale 1ns/1ps
module gpio_override_port_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       busWr;
  logic [1:0] busAddr;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic [7:0] periOut;
  logic [7:0] periOe;
  logic [7:0] padIn;
  logic [7:0] padOut;
  logic [7:0] padOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_override_port uut (
    .clk(clk), .rst(rst), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .periOut(periOut),
    .periOe(periOe), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [7:0] expOut(logic [7:0] s, logic [7:0] l, logic [7:0] po);
    return (s & po) | (~s & l);
  endfunction

  function automatic logic [7:0] expOe(logic [7:0] s, logic [7:0] d, logic [7:0] pe);
    return (s & pe) | (~s & ~d);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; busWr = 1'b0; busAddr = 2'd0; busWrData = '0;
    periOut = 8'hFF; periOe = 8'hFF; padIn = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    busRead(2'd1, rd); check("R1 dir", rd, 8'hFF);
    busRead(2'd2, rd); check("R1 sel", rd, 8'h00);

    // R3/R4/R6/R8: sweep every select pattern
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sv, dv, lv, po, pe;
      sv = 8'(s);
      dv = 8'((s * 37 + 11) & 255);
      lv = 8'((s * 91) ^ 8'hA5);
      po = 8'(~(s * 3));
      pe = 8'(s ^ 8'h3C);
      busWrite(2'd2, sv);
      busWrite(2'd1, dv);
      busWrite(2'd0, lv);
      periOut = po; periOe = pe;
      #1;
      check("R3/R4 padOut", padOut, expOut(sv, lv, po));
      check("R3/R4 padOe", padOe, expOe(sv, dv, pe));
      busRead(2'd1, rd); check("R6 dir readback", rd, dv);
      busRead(2'd2, rd); check("R8 sel readback", rd, sv);
    end

    // R5: peripheral inputs ignored when not selected
    busWrite(2'd2, 8'h00);
    busWrite(2'd1, 8'h0F);
    busWrite(2'd0, 8'h3C);
    for (int v = 0; v < 16; v++) begin
      periOut = 8'(v * 17); periOe = 8'(~(v * 17));
      #1;
      check("R5 padOut", padOut, 8'h3C);
      check("R5 padOe", padOe, 8'hF0);
    end

    // R6: direction write under full override is stored, pads unaffected
    periOut = 8'hA5; periOe = 8'h5A;
    busWrite(2'd2, 8'hFF);
    busWrite(2'd1, 8'h81);
    #1;
    check("R6 padOe under override", padOe, 8'h5A);
    busRead(2'd1, rd); check("R6 stored dir", rd, 8'h81);

    // R2/R7: pin readback comes from synchronized pads
    busWrite(2'd2, 8'h00);
    busWrite(2'd0, 8'hFF);
    busAddr = 2'd0;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] oldV, newV;
      @(negedge clk);
      busRead(2'd0, oldV);
      newV = 8'(v * 29 + 1);
      padIn = newV;
      @(negedge clk);
      busRead(2'd0, rd); check("R7 one edge", rd, oldV);
      @(negedge clk);
      busRead(2'd0, rd); check("R7/R2 two edges", rd, newV);
    end
    padIn = 8'h00;
    repeat (2) @(negedge clk);
    busRead(2'd0, rd); check("R2 not latch", rd, 8'h00);

    // R9: unused address
    busWrite(2'd1, 8'h33);
    busWrite(2'd2, 8'h0C);
    busWrite(2'd0, 8'h66);
    busWrite(2'd3, 8'hC9);
    busRead(2'd3, rd); check("R9 read zero", rd, 8'h00);
    busRead(2'd1, rd); check("R9 dir kept", rd, 8'h33);
    busRead(2'd2, rd); check("R9 sel kept", rd, 8'h0C);
    #1;
    check("R9 latch kept", padOut, expOut(8'h0C, 8'h66, periOut));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule